// File: doc/BRIEF.md
# Framebuffer Control Register Window with Vertical-Sync Interrupt

This block is the register slice of a simple framebuffer controller. It decodes a 32-byte byte-wide window. A control register holds the interrupt enable. A status register returns a sticky interrupt-pending flag merged with fixed identification bits. Fourteen plain storage bytes hold cursor and video-control settings that other logic reads. The two palette offsets in the lower half of the window belong to another block, so here they and the rest of the lower half read as zero and ignore writes.

A video timing generator supplies a one-cycle vertical-sync pulse. When the enable bit is set, each pulse latches the pending flag. The interrupt output is a level equal to that flag. Software acknowledges the interrupt by writing any value to the status offset. Reads are combinational from the address and have no side effects. Writes take effect at the rising clock edge.

Top module: `fbctl_regs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the control register, the pending flag and all storage bytes read zero and `irq` is low.
- R2: Offset 0x10 is the control register: 8 bits, written whole on a write strobe and read back unchanged.
- R3: A vsync pulse sampled while control bit 7 holds 1 (the value before that edge) sets the pending flag, and `irq` is high from the next cycle.
- R4: A vsync pulse sampled while control bit 7 holds 0 leaves the pending flag and `irq` unchanged.
- R5: A read of offset 0x11 returns the pending flag in bit 7 and the constant 7'h61 in bits 6:0 (monitor code 0x60 ORed with colour identifier 0x01).
- R6: Any write to offset 0x11 clears the pending flag and lowers `irq` in the next cycle, whatever the data. It changes no other register.
- R7: When a qualifying vsync pulse and a status write fall in the same cycle, the flag ends up set.
- R8: `irq` always equals the pending flag. The flag is sticky: clearing the enable bit does not clear it, and only reset or a status write does.
- R9: Offsets 0x12 to 0x1F are fourteen independent 8-bit storage registers. A write changes only the addressed byte.
- R10: Offsets 0x00 to 0x0F read zero. Writes there change no register and do not affect `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte offset within the window |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| vsync_pulse | input | 1 | One-cycle vertical-sync event |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench targets a vsync pulse that lands in the same cycle as a status write. A design that lets the acknowledge win there drops an interrupt. It writes the control register in the same cycle as a pulse to show that the enable is taken from the old value. It clears the enable while an interrupt is pending, which exposes a flag that is not sticky. It writes status with random and all-zero data, which catches a design that clears only on certain bits or disturbs other registers. Writes to the lower half are followed by a full readback, which shows any aliasing onto storage or control. Random traffic then compares every read and every `irq` sample against a bench model.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_STORE  = 14;
    localparam int IDX_W      = $clog2(NUM_STORE);
    localparam int IEN_BIT    = 7;
    localparam int PEND_BIT   = 7;

    localparam logic [ADDR_W-1:0] CTRL_OFS   = 5'h10;
    localparam logic [ADDR_W-1:0] STAT_OFS   = 5'h11;
    localparam logic [ADDR_W-1:0] STORE_BASE = 5'h12;
    localparam logic [DATA_W-1:0] ID_CODE    = 8'h61;

    typedef struct packed {
        logic             low;
        logic             ctrl;
        logic             stat;
        logic             store;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              pend;
    } irq_st_t;
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    output dec_t                 dec,
    output logic [NUM_STORE-1:0] store_we
);
    logic [ADDR_W-1:0] off;

    always_comb begin
        off       = addr - STORE_BASE;
        dec       = '0;
        dec.low   = (addr < CTRL_OFS);
        dec.ctrl  = (addr == CTRL_OFS);
        dec.stat  = (addr == STAT_OFS);
        dec.store = (addr >= STORE_BASE);
        dec.idx   = off[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_STORE; g++) begin : g_we
        assign store_we[g] = wr_en && dec.store && (dec.idx == IDX_W'(g));
    end
endmodule

// File: rtl/fbctl_irq.sv
module fbctl_irq
    import fbctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vsync_pulse,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              pend_q
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.ctrl = wr_data;
        if (stat_wr) st_d.pend = 1'b0;
        // a qualifying event beats the acknowledge
        if (vsync_pulse && st_q.ctrl[IEN_BIT]) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;
    assign pend_q = st_q.pend;
endmodule

// File: rtl/fbctl_store.sv
module fbctl_store
    import fbctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_STORE-1:0] we,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data
);
    logic [NUM_STORE-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < NUM_STORE; i++) begin
            if (we[i]) mem_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_STORE; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
        end
    end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              vsync_pulse,
    output logic              irq
);
    dec_t                 dec;
    logic [NUM_STORE-1:0] store_we;
    logic [DATA_W-1:0]    ctrl_q;
    logic                 pend_q;
    logic [DATA_W-1:0]    store_rd;

    fbctl_decode u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .dec      (dec),
        .store_we (store_we)
    );

    fbctl_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (wr_en && dec.ctrl),
        .stat_wr     (wr_en && dec.stat),
        .wr_data     (wr_data),
        .vsync_pulse (vsync_pulse),
        .ctrl_q      (ctrl_q),
        .pend_q      (pend_q)
    );

    fbctl_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .wr_data (wr_data),
        .rd_idx  (dec.idx),
        .rd_data (store_rd)
    );

    always_comb begin
        rd_data = '0;
        if (dec.ctrl)       rd_data = ctrl_q;
        else if (dec.stat)  rd_data = ID_CODE | (DATA_W'(pend_q) << PEND_BIT);
        else if (dec.store) rd_data = store_rd;
    end

    assign irq = pend_q;
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk
    import fbctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              vsync_pulse,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              irq
);
    logic fire;
    logic ack;
    assign fire = vsync_pulse && ctrl_q[IEN_BIT];
    assign ack  = wr_en && (addr == STAT_OFS);

    // R3
    vsync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> !irq);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && fire) |=> irq);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !$rose(irq));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == STAT_OFS) |-> (rd_data == {irq, 7'h61}));

    // R10
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < CTRL_OFS) |-> (rd_data == '0));
endmodule

bind fbctl_regs fbctl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .vsync_pulse (vsync_pulse),
    .ctrl_q      (ctrl_q),
    .irq         (irq)
);

// File: tb/fbctl_regs_bench.sv
module fbctl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       vsync_pulse = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_ctrl;
    logic       m_pend;
    logic [7:0] m_store [14];

    always #2 clk = ~clk;

    fbctl_regs u_fbctl_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .vsync_pulse(vsync_pulse), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a < 5'h10)       return 8'h00;
        else if (a == 5'h10) return m_ctrl;
        else if (a == 5'h11) return {m_pend, 7'h61};
        else                 return m_store[a - 5'h12];
    endfunction

    function automatic string req_of(input logic [4:0] a);
        if (a < 5'h10)       return "R10";
        else if (a == 5'h10) return "R2";
        else if (a == 5'h11) return "R5";
        else                 return "R9";
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ctrl = '0;
        m_pend = 1'b0;
        for (int i = 0; i < 14; i++) m_store[i] = '0;
    endtask

    // one bus cycle: drive, check read before the edge, update model, check irq after
    task automatic step(input logic [4:0] a, input bit w, input logic [7:0] d,
                        input bit vs, input string irq_req);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; wr_en = w; wr_data = d; vsync_pulse = vs;
        #0.5;
        exp = exp_read(a);
        check(rd_data == exp, req_of(a), rd_data, exp);
        if (vs && m_ctrl[7])            m_pend = 1'b1;
        else if (w && a == 5'h11)       m_pend = 1'b0;
        if (w && a == 5'h10)            m_ctrl = d;
        if (w && a >= 5'h12)            m_store[a - 5'h12] = d;
        @(posedge clk);
        #0.5;
        check(irq == m_pend, irq_req, {7'b0, irq}, {7'b0, m_pend});
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 32; a++) step(5'(a), 1'b0, 8'h00, 1'b0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #0.5;
        // R1: irq low and reads zero during reset
        check(irq == 1'b0, "R1", {7'b0, irq}, 8'h00);
        addr = 5'h10; #0.1;
        check(rd_data == 8'h00, "R1", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R1");

        // R2 / R9: directed writes
        step(5'h10, 1, 8'h5A, 0, "R2");
        step(5'h12, 1, 8'hA5, 0, "R9");
        step(5'h1F, 1, 8'h3C, 0, "R9");
        read_all("R9");

        // R4: enable clear, vsync ignored
        step(5'h11, 0, 8'h00, 1, "R4");
        // R3: enable, vsync sets pending
        step(5'h10, 1, 8'h80, 0, "R2");
        step(5'h11, 0, 8'h00, 1, "R3");
        // R8: clearing enable keeps pending
        step(5'h10, 1, 8'h00, 0, "R8");
        step(5'h11, 0, 8'h00, 0, "R8");
        // R6: status write with zero data clears
        step(5'h11, 1, 8'h00, 0, "R6");
        read_all("R6");
        // R7: set beats clear in the same cycle
        step(5'h10, 1, 8'h80, 0, "R2");
        step(5'h11, 1, 8'hFF, 1, "R7");
        step(5'h11, 0, 8'h00, 0, "R7");
        // R3: control written in the same cycle as vsync, old enable used
        step(5'h11, 1, 8'h12, 0, "R6");
        step(5'h10, 1, 8'h00, 1, "R3");
        step(5'h10, 1, 8'h80, 1, "R4");
        step(5'h11, 0, 8'h00, 0, "R4");
        // R10: low writes change nothing
        for (int a = 0; a < 16; a++) step(5'(a), 1, 8'hFF, 0, "R10");
        read_all("R10");

        // constrained random
        void'($urandom(32'h1F2E3D4C));
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] ra;
            ra = 5'($urandom_range(31, 0));
            if ($urandom_range(3, 0) == 0) ra = 5'h11;
            else if ($urandom_range(5, 0) == 0) ra = 5'h10;
            step(ra, ($urandom_range(2, 0) == 0), 8'($urandom),
                 ($urandom_range(9, 0) == 0), "R8");
        end

        // reset again mid-run with state loaded
        step(5'h10, 1, 8'h80, 0, "R2");
        step(5'h11, 0, 8'h00, 1, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        read_all("R1");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule